// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block takes a page-mode DRAM from power-on to a usable state and then keeps its contents alive. After reset it holds off for a programmable power-up pause. It then runs a fixed number of warm-up refresh cycles and raises `init_done`. From then on it adds one pending refresh every refresh interval, which is sized so that every row is refreshed within the retention period. It asks the access controller for the memory bus and, once granted, performs each pending refresh.

Every refresh uses CAS-before-RAS ordering, so the DRAM's internal row counter picks the row and no address is driven. All CAS lanes fall together ahead of RAS and stay low for a hold time after RAS falls. Write enable is held high for the whole cycle. RAS then stays high for a precharge time before the next cycle. Address, output enable and data are not driven by this block, because they are don't-care during this kind of refresh.

Refreshes that the controller postpones are counted in a saturating debt counter. The request stays up while the count is nonzero. When the count reaches its ceiling the request is flagged urgent, and the controller must give up the bus at its next word boundary. Every time is a parameter counted in clock cycles.

The controller is a single state machine:
- `ST_PWRUP` runs the pause and leaves for `ST_IDLE` when its timer expires.
- `ST_IDLE` moves to `ST_REQ` when warm-up cycles or debt remain.
- `ST_REQ` moves to `ST_SETUP` when the grant is present.
- The refresh cycle itself runs `ST_SETUP`, then `ST_CAS_LEAD`, then `ST_RAS_ACT`, then `ST_RAS_HOLD`, then `ST_PRECH`. Each of these states lasts its own parameter count.
- `ST_PRECH` returns to `ST_IDLE` and retires one warm-up cycle or one unit of debt.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, every `cas_n` lane and `we_n` are high, and `bus_own`, `ref_req`, `ref_urgent` and `init_done` are low.
- R2: `ref_req` stays low for at least `PWRUP_CYC` clock cycles after reset is released, and rises within a few cycles after that.
- R3: In each refresh cycle all CAS lanes fall together and are low for exactly `T_CSR` cycles before RAS falls. CAS stays low for exactly `T_CHR` cycles counted from the RAS fall. RAS stays low for exactly `T_CHR + T_RASH` cycles. CAS is high again before RAS rises.
- R4: `we_n` is high in every cycle in which `bus_own` is high.
- R5: After the pause, exactly `WARMUP` refresh cycles run. `init_done` then rises and stays high, and `ref_req` is low at that moment.
- R6: After `init_done`, each `INTERVAL_CYC` cycles add one pending refresh, up to `DEBT_MAX`. When the grant is withheld for k intervals, granting it produces exactly min(k, `DEBT_MAX`) refresh cycles.
- R7: `ref_req` is high while any refresh is pending and drops once the last one completes. `bus_own` is only high while `bus_grant` is high. While the grant is withheld, `ras_n` stays high and `bus_own` stays low.
- R8: `ref_urgent` is high exactly when the pending count equals `DEBT_MAX`, and is never high without `ref_req`.
- R9: Before each RAS fall, RAS has been high for at least `T_RP + T_RPC + T_CSR` cycles. This covers the precharge, the RAS-to-CAS precharge and the CAS lead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | Access controller hands the DRAM bus to this block |
| ref_req | output | 1 | Refresh wanted (warm-up or pending debt) |
| ref_urgent | output | 1 | Debt at its ceiling; controller must yield soon |
| bus_own | output | 1 | This block is driving RAS, CAS and write enable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | LANES | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| init_done | output | 1 | Warm-up finished, normal accesses allowed |

## Verification
The properties take for granted that the access controller raises `bus_grant` only while `ref_req` is high, and keeps it high until `ref_req` falls. Because of this, the property that ties `bus_own` to the grant holds only under that handshake. The bench follows the rule exactly: it raises the grant only after it sees the request, and drops it on the first sample where the request is low. The postponement vectors hold the grant off for a whole number of intervals plus a half. Each grant therefore lands midway between timer ticks, and all pending cycles finish before the next tick arrives. This makes the expected count of refreshes exact.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_REQ      = 3'd2,
        ST_SETUP    = 3'd3,
        ST_CAS_LEAD = 3'd4,
        ST_RAS_ACT  = 3'd5,
        ST_RAS_HOLD = 3'd6,
        ST_PRECH    = 3'd7
    } rf_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drfsh_interval_timer.sv
module drfsh_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= RELOAD;
            tick <= 1'b0;
        end else if (!run) begin
            cnt  <= RELOAD;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= RELOAD;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end

    generate
        if (INTERVAL_CYC > 1) begin : g_tick_chk
            p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("interval tick lasted more than one cycle");
        end
    endgenerate

endmodule

// File: rtl/drfsh_debt_counter.sv
module drfsh_debt_counter #(
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic retire,
    output logic pending,
    output logic full
);
    localparam int unsigned DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] CEIL = DW'(DEBT_MAX);

    logic [DW-1:0] debt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt <= '0;
        end else begin
            unique case ({add, retire})
                2'b10: if (debt != CEIL) debt <= debt + 1'b1;
                2'b01: if (debt != '0)   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign pending = (debt != '0);
    assign full    = (debt == CEIL);

    p_debt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= CEIL)
        else $error("refresh debt above ceiling");

    p_debt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!add && !retire) |=> (debt == $past(debt)))
        else $error("refresh debt moved without a tick or a retire");

endmodule

// File: rtl/drfsh_cycle_fsm.sv
module drfsh_cycle_fsm
    import drfsh_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 50000,
    parameter int unsigned WARMUP    = 8,
    parameter int unsigned T_RPC     = 2,
    parameter int unsigned T_CSR     = 2,
    parameter int unsigned T_CHR     = 3,
    parameter int unsigned T_RASH    = 12,
    parameter int unsigned T_RP      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_grant,
    input  logic debt_pending,
    output logic ras_n,
    output logic cas_low,
    output logic we_n,
    output logic own,
    output logic ref_req,
    output logic init_done,
    output logic retire
);
    localparam int unsigned MAXT = max2(max2(max2(PWRUP_CYC, T_RPC), max2(T_CSR, T_CHR)),
                                        max2(T_RASH, T_RP));
    localparam int unsigned PH_W = $clog2(MAXT + 1);
    localparam int unsigned WW   = $clog2(WARMUP + 1);

    localparam logic [PH_W-1:0] L_PWR  = PH_W'(PWRUP_CYC - 1);
    localparam logic [PH_W-1:0] L_RPC  = PH_W'(T_RPC - 1);
    localparam logic [PH_W-1:0] L_CSR  = PH_W'(T_CSR - 1);
    localparam logic [PH_W-1:0] L_CHR  = PH_W'(T_CHR - 1);
    localparam logic [PH_W-1:0] L_RASH = PH_W'(T_RASH - 1);
    localparam logic [PH_W-1:0] L_RP   = PH_W'(T_RP - 1);

    rf_state_e       state, state_nx;
    logic [PH_W-1:0] ph_cnt, ph_load;
    logic [WW-1:0]   warm_left;
    logic            ph_zero, need, cyc_end;

    assign ph_zero = (ph_cnt == '0);
    assign need    = (warm_left != '0) || (init_done && debt_pending);
    assign cyc_end = (state == ST_PRECH) && ph_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP:    if (ph_zero)   state_nx = ST_IDLE;
            ST_IDLE:     if (need)      state_nx = ST_REQ;
            ST_REQ:      if (bus_grant) state_nx = ST_SETUP;
            ST_SETUP:    if (ph_zero)   state_nx = ST_CAS_LEAD;
            ST_CAS_LEAD: if (ph_zero)   state_nx = ST_RAS_ACT;
            ST_RAS_ACT:  if (ph_zero)   state_nx = ST_RAS_HOLD;
            ST_RAS_HOLD: if (ph_zero)   state_nx = ST_PRECH;
            ST_PRECH:    if (ph_zero)   state_nx = ST_IDLE;
            default:                    state_nx = ST_PWRUP;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        ph_load = '0;
        unique case (state_nx)
            ST_SETUP:    ph_load = L_RPC;
            ST_CAS_LEAD: ph_load = L_CSR;
            ST_RAS_ACT:  ph_load = L_CHR;
            ST_RAS_HOLD: ph_load = L_RASH;
            ST_PRECH:    ph_load = L_RP;
            ST_PWRUP:    ph_load = L_PWR;
            default:     ph_load = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ph_cnt <= L_PWR;
        else if (state_nx != state) ph_cnt <= ph_load;
        else if (!ph_zero)          ph_cnt <= ph_cnt - 1'b1;
    end

    // warm-up bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_left <= WW'(WARMUP);
            init_done <= 1'b0;
        end else if (cyc_end && !init_done) begin
            warm_left <= warm_left - 1'b1;
            if (warm_left == WW'(1)) init_done <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ras_n   = 1'b1;
        cas_low = 1'b0;
        we_n    = 1'b1;
        own     = 1'b0;
        unique case (state)
            ST_PWRUP, ST_IDLE, ST_REQ: own = 1'b0;
            ST_SETUP:    own = 1'b1;
            ST_CAS_LEAD: begin own = 1'b1; cas_low = 1'b1; end
            ST_RAS_ACT:  begin own = 1'b1; cas_low = 1'b1; ras_n = 1'b0; end
            ST_RAS_HOLD: begin own = 1'b1; ras_n = 1'b0; end
            ST_PRECH:    own = 1'b1;
            default:     own = 1'b0;
        endcase
        ref_req = (state != ST_PWRUP) && need;
        retire  = cyc_end && init_done;
    end

    p_cas_before_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(cas_low))
        else $error("RAS fell without CAS already low");

    p_cas_up_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> !cas_low)
        else $error("CAS still low when RAS rose");

    p_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        own |-> we_n)
        else $error("write enable low during refresh");

    p_own_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        own |-> bus_grant)
        else $error("bus driven without grant");

    p_init_after_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(state) == ST_PRECH))
        else $error("init_done rose outside a cycle end");

    p_init_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done)
        else $error("init_done dropped");

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int unsigned LANES        = 4,
    parameter int unsigned PWRUP_CYC    = 50000,
    parameter int unsigned WARMUP       = 8,
    parameter int unsigned INTERVAL_CYC = 3900,
    parameter int unsigned DEBT_MAX     = 8,
    parameter int unsigned T_RPC        = 2,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned T_CHR        = 3,
    parameter int unsigned T_RASH       = 12,
    parameter int unsigned T_RP         = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_grant,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             bus_own,
    output logic             ras_n,
    output logic [LANES-1:0] cas_n,
    output logic             we_n,
    output logic             init_done
);
    logic tick, retire, debt_pending, debt_full, cas_low;

    drfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_done),
        .tick  (tick)
    );

    drfsh_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (tick),
        .retire  (retire),
        .pending (debt_pending),
        .full    (debt_full)
    );

    drfsh_cycle_fsm #(
        .PWRUP_CYC (PWRUP_CYC),
        .WARMUP    (WARMUP),
        .T_RPC     (T_RPC),
        .T_CSR     (T_CSR),
        .T_CHR     (T_CHR),
        .T_RASH    (T_RASH),
        .T_RP      (T_RP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_grant    (bus_grant),
        .debt_pending (debt_pending),
        .ras_n        (ras_n),
        .cas_low      (cas_low),
        .we_n         (we_n),
        .own          (bus_own),
        .ref_req      (ref_req),
        .init_done    (init_done),
        .retire       (retire)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign cas_n[g] = ~cas_low;
        end
    endgenerate

    assign ref_urgent = init_done && debt_full;

    p_urgent_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req)
        else $error("urgent without request");

endmodule

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
module dram_refresh_seq_bench;
    localparam int LANES = 4, PWRUP = 20, WARMUP = 8, INTERVAL = 120, DEBT_MAX = 4;
    localparam int T_RPC = 1, T_CSR = 1, T_CHR = 2, T_RASH = 3, T_RP = 2;

    // {intervals withheld, expected refreshes, expected urgent}
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{'{1,1,0}, '{2,2,0}, '{3,3,0}, '{4,4,1}, '{6,4,1}};

    logic clk = 1'b0, rst_n = 1'b0, bus_grant = 1'b0;
    logic ref_req, ref_urgent, bus_own, ras_n, we_n, init_done;
    logic [LANES-1:0] cas_n;

    int n_chk = 0, n_fail = 0, ras_falls = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .LANES(LANES), .PWRUP_CYC(PWRUP), .WARMUP(WARMUP), .INTERVAL_CYC(INTERVAL),
        .DEBT_MAX(DEBT_MAX), .T_RPC(T_RPC), .T_CSR(T_CSR), .T_CHR(T_CHR),
        .T_RASH(T_RASH), .T_RP(T_RP)
    ) u_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_req(input logic val, input int lim, input string req);
        int n = 0;
        while (ref_req !== val && n < lim) begin
            @(negedge clk);
            n++;
        end
        check(ref_req === val, req, int'(ref_req), int'(val));
    endtask

    // waveform monitor
    int cas_lead = 0, ras_run = 0, cas_after = 0, ras_high = 0;
    logic prev_ras = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            cas_lead = 0; ras_run = 0; cas_after = 0; ras_high = 0; prev_ras = 1'b1;
        end else begin
            if (bus_own) begin
                check(we_n === 1'b1, "R4 we_n high while owning", int'(we_n), 1);
                check(bus_grant === 1'b1, "R7 own only with grant", int'(bus_grant), 1);
                check(cas_n == '0 || cas_n == '1, "R3 lanes move together", int'(cas_n), 0);
            end
            if (prev_ras && !ras_n) begin
                ras_falls++;
                check(cas_lead == T_CSR, "R3 CAS lead before RAS", cas_lead, T_CSR);
                check(ras_high >= T_RP + T_RPC + T_CSR, "R9 RAS high before fall",
                      ras_high, T_RP + T_RPC + T_CSR);
                ras_run = 1;
                cas_after = (cas_n == '0) ? 1 : 0;
            end else if (!ras_n) begin
                ras_run++;
                if (cas_n == '0) cas_after++;
            end else if (!prev_ras && ras_n) begin
                check(ras_run == T_CHR + T_RASH, "R3 RAS low width", ras_run, T_CHR + T_RASH);
                check(cas_after == T_CHR, "R3 CAS hold after RAS", cas_after, T_CHR);
            end
            if (ras_n) ras_high++; else ras_high = 0;
            if (ras_n && cas_n == '0) cas_lead++; else cas_lead = 0;
            prev_ras = ras_n;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cyc, f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ras_n === 1'b1, "R1 ras_n", int'(ras_n), 1);
        check(cas_n === '1, "R1 cas_n", int'(cas_n), (1 << LANES) - 1);
        check(we_n === 1'b1, "R1 we_n", int'(we_n), 1);
        check(bus_own === 1'b0 && ref_req === 1'b0 && ref_urgent === 1'b0,
              "R1 own/req/urgent", int'({bus_own, ref_req, ref_urgent}), 0);
        check(init_done === 1'b0, "R1 init_done", int'(init_done), 0);
        rst_n = 1'b1;

        // R2 power-up pause
        cyc = 0;
        while (!ref_req && cyc < PWRUP + 50) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc >= PWRUP && cyc <= PWRUP + 3, "R2 pause length", cyc, PWRUP);
        check(init_done === 1'b0, "R5 not ready during warm-up", int'(init_done), 0);

        // R5 warm-up
        f0 = ras_falls;
        bus_grant = 1'b1;
        cyc = 0;
        while (!init_done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(ras_falls - f0 == WARMUP, "R5 warm-up cycle count", ras_falls - f0, WARMUP);
        check(ref_req === 1'b0, "R5 request low at ready", int'(ref_req), 0);
        bus_grant = 1'b0;

        // R6 R7 R8 postponement vectors
        for (int v = 0; v < NV; v++) begin
            wait_req(1'b1, 2 * INTERVAL, "R6 request after a tick");
            repeat ((VEC[v][0] - 1) * INTERVAL + INTERVAL / 2) @(negedge clk);
            check(bus_own === 1'b0 && ras_n === 1'b1, "R7 idle while grant withheld",
                  int'({bus_own, ras_n}), 1);
            check(ref_req === 1'b1, "R7 request held", int'(ref_req), 1);
            check(ref_urgent === VEC[v][2][0], "R8 urgent flag", int'(ref_urgent), VEC[v][2]);
            f0 = ras_falls;
            bus_grant = 1'b1;
            @(negedge clk);
            wait_req(1'b0, 500, "R7 request drops when debt cleared");
            bus_grant = 1'b0;
            check(ras_falls - f0 == VEC[v][1], "R6 refreshes after postponement",
                  ras_falls - f0, VEC[v][1]);
            check(ref_urgent === 1'b0, "R8 urgent clear after catch-up", int'(ref_urgent), 0);
            @(negedge clk);
            check(bus_own === 1'b0, "R7 bus released", int'(bus_own), 0);
        end

        // R1 reset in the middle of a cycle
        wait_req(1'b1, 2 * INTERVAL, "R6 request before mid-cycle reset");
        bus_grant = 1'b1;
        cyc = 0;
        while (ras_n && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        rst_n = 1'b0;
        bus_grant = 1'b0;
        #1;
        check(ras_n === 1'b1 && cas_n === '1, "R1 strobes high on mid-cycle reset",
              int'({ras_n, cas_n}), (1 << (LANES + 1)) - 1);
        check(bus_own === 1'b0 && init_done === 1'b0 && ref_req === 1'b0,
              "R1 flags low on mid-cycle reset", int'({bus_own, init_done, ref_req}), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule